// File: doc/BRIEF.md
# Split-line I2C target with strap-selected address

This block is a serial-bus target for a peripheral controller. The bus master generates every clock edge and starts every transfer. The block only watches the clock line. Received data comes in on an input-only line. Acknowledge bits and read data go out on a separate open-drain output, which can only pull the line low or let it go. Keeping the two data directions apart lets the block sit behind optocouplers. On an ordinary board the two data lines are simply tied together.

The 7-bit target address has three fixed upper bits, 0,1,0. The four lower bits come from strap pins. The pins are sampled once, on the first system clock after reset is released, and are ignored after that. An open strap pin reads as 1 because of a board pull-up, so the default address is 2Fh. The block also answers the global write address byte 30h.

Bus clock and data are synchronized to the system clock, and every bus event is detected on those samples. In a write, the first data byte after the address sets an 8-bit register pointer. Each later byte is written at the pointer, and the pointer then steps up by one. A read returns the byte at the pointer, most significant bit first, and the pointer then steps up by one.

Top module: `i2c_strap_slave`

## Requirements
- R1: While reset is asserted, `sda_pull_low` and `reg_we` are 0.
- R2: An address byte whose upper seven bits equal {010, strap} is acknowledged by pulling `sda_pull_low` during the ninth clock, for both R/W=0 (write) and R/W=1 (read).
- R3: The strap value is the one on `strap_pins` at the first clock after reset release; later changes on the pins do not change the address that is acknowledged.
- R4: The address byte 30h (7-bit address 18h with R/W=0) is acknowledged and starts a write transfer; 31h is not acknowledged.
- R5: An address byte that matches neither address is not acknowledged, and later bytes up to the next START are neither acknowledged nor written.
- R6: In a write, the first data byte loads the pointer and each later byte is written to `reg_addr` = pointer, with the pointer then incremented; every data byte is acknowledged.
- R7: In a read, each byte sent is `reg_rdata` at the pointer, MSB first, and the pointer then increments; the pointer keeps its value across transfers.
- R8: After the master leaves the acknowledge bit of a read byte high (NACK), the output stays released until the next START.
- R9: A repeated START without a STOP restarts address decoding, so a write that sets the pointer can be followed directly by a read.
- R10: A STOP or START in the middle of a byte discards that byte, so no partial byte is written, and `sda_pull_low` is released.
- R11: `sda_pull_low` changes only just after a falling edge of the bus clock, or on START or STOP, never while the clock is high.
- R12: `reg_we` is a single system-clock pulse for each written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pins | input | 4 | Address strap pins, sampled once after reset |
| scl_in | input | 1 | Bus clock from the master |
| sda_in | input | 1 | Bus data input |
| sda_pull_low | output | 1 | Open-drain data output: 1 pulls the line low |
| reg_addr | output | 8 | Register pointer, used as address for reads and writes |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_we | output | 1 | Write strobe, one cycle per byte |
| reg_rdata | input | 8 | Read data at reg_addr |

## Verification
A wrong bit counter or state shifts the acknowledge slot. The master then sees a missing or misplaced ACK in the same byte, and wrongly placed writes show up when register contents are compared after the next STOP. A stale strap latch or a broken address comparator shows up in the address sweep: all 256 address bytes and all 16 strap values are tried, and the wrong acknowledge appears on the ninth clock. A pointer that fails to increment, or increments twice, shows up as wrong read data on the very next byte. A pointer that is not kept between transfers shows up on the first byte of the following read.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } slv_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int         W       = 2,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data edges only count as bus conditions while the clock stays high
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cs_strap.sv
module i2cs_strap #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] strap_q,
  output logic         strap_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q   <= '1;
      strap_vld <= 1'b0;
    end else if (!strap_vld) begin
      strap_q   <= pins;
      strap_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave #(
  parameter int                 STRAP_W     = 4,
  parameter logic [6-STRAP_W:0] ADDR_PREFIX = 3'b010,
  parameter logic [7:0]         GLOBAL_BYTE = 8'h30,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull_low,
  output logic [7:0]         reg_addr,
  output logic [7:0]         reg_wdata,
  output logic               reg_we,
  input  logic [7:0]         reg_rdata
);
  import i2cs_pkg::*;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_p, stop_p;
  logic [STRAP_W-1:0] strap_q;
  logic strap_vld;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
  );

  i2cs_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
  );

  i2cs_strap #(.W(STRAP_W)) u_strap (
    .clk(clk), .rst_n(rst_n), .pins(strap_pins),
    .strap_q(strap_q), .strap_vld(strap_vld)
  );

  slv_state_e         st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [BYTE_W-1:0]  sh_q, sh_n;
  logic [7:0]         ptr_q, ptr_n;
  logic [BYTE_W-1:0]  wd_q, wd_n;
  logic addr_ph_q, addr_ph_n;
  logic rw_q, rw_n;
  logic ptr_set_q, ptr_set_n;
  logic drv_q, drv_n;
  logic we_q, we_n;
  logic inc_q, inc_n;

  logic hit_own, hit_glob, load_rd;

  assign hit_own  = (sh_q[7:1] == {ADDR_PREFIX, strap_q});
  assign hit_glob = (sh_q == GLOBAL_BYTE);

  // a read byte is fetched after the address ACK of a read, or after a master ACK
  assign load_rd = scl_fall &&
                   (((st_q == ST_ACK) && rw_q) ||
                    ((st_q == ST_MACK) && (cnt_q == CNT_W'(1))));

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    ptr_n     = ptr_q;
    wd_n      = wd_q;
    addr_ph_n = addr_ph_q;
    rw_n      = rw_q;
    ptr_set_n = ptr_set_q;
    drv_n     = drv_q;
    we_n      = 1'b0;
    inc_n     = inc_q;

    if (stop_p) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      drv_n = 1'b0;
      inc_n = 1'b0;
    end else if (start_p) begin
      st_n      = ST_RX;
      cnt_n     = '0;
      addr_ph_n = 1'b1;
      ptr_set_n = 1'b0;
      drv_n     = 1'b0;
      inc_n     = 1'b0;
    end else if (load_rd) begin
      sh_n  = reg_rdata;
      drv_n = ~reg_rdata[7];
      ptr_n = ptr_q + 1'b1;
      cnt_n = '0;
      st_n  = ST_TX;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && (cnt_q != LAST_BIT)) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == LAST_BIT)) begin
            cnt_n = '0;
            if (addr_ph_q) begin
              if (hit_own || hit_glob) begin
                drv_n     = 1'b1;
                rw_n      = sh_q[0];
                addr_ph_n = 1'b0;
                st_n      = ST_ACK;
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              drv_n = 1'b1;
              st_n  = ST_ACK;
              if (!ptr_set_q) begin
                ptr_n     = sh_q;
                ptr_set_n = 1'b1;
              end else begin
                we_n  = 1'b1;
                wd_n  = sh_q;
                inc_n = 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            drv_n = 1'b0;
            cnt_n = '0;
            st_n  = ST_RX;
            inc_n = 1'b0;
            if (inc_q) ptr_n = ptr_q + 1'b1;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              drv_n = 1'b0;
              cnt_n = '0;
              st_n  = ST_MACK;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              drv_n = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_s) st_n = ST_IDLE;
            else       cnt_n = CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      ptr_q     <= '0;
      wd_q      <= '0;
      addr_ph_q <= 1'b0;
      rw_q      <= 1'b0;
      ptr_set_q <= 1'b0;
      drv_q     <= 1'b0;
      we_q      <= 1'b0;
      inc_q     <= 1'b0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      sh_q      <= sh_n;
      ptr_q     <= ptr_n;
      wd_q      <= wd_n;
      addr_ph_q <= addr_ph_n;
      rw_q      <= rw_n;
      ptr_set_q <= ptr_set_n;
      drv_q     <= drv_n;
      we_q      <= we_n;
      inc_q     <= inc_n;
    end
  end

  assign sda_pull_low = drv_q;
  assign reg_addr     = ptr_q;
  assign reg_wdata    = wd_q;
  assign reg_we       = we_q;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter int STRAP_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sda_pull_low,
  input logic               reg_we,
  input logic               scl_fall,
  input logic               start_p,
  input logic               stop_p,
  input logic [STRAP_W-1:0] strap_q,
  input logic               strap_vld
);
  always_comb begin
    if (!rst_n) begin
      assert_idle_in_reset_R1: assert (!sda_pull_low && !reg_we);
    end
  end

  assert_strap_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_vld && $past(strap_vld)) |-> $stable(strap_q));

  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_pull_low);

  assert_drive_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_low) |-> $past(scl_fall || start_p || stop_p));

  assert_we_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
endmodule

bind i2c_strap_slave i2cs_checker #(.STRAP_W(STRAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_low(sda_pull_low), .reg_we(reg_we),
  .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
  .strap_q(strap_q), .strap_vld(strap_vld)
);

// File: tb/tb_i2c_strap_slave.sv
module tb_i2c_strap_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] strap = 4'hF;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic bus_sda, sda_pull_low, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  int wr_cnt = 0;
  int checks = 0, fails = 0, cyc = 0;
  int scl_hi = 0, viol = 0;
  logic prev_drv = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  assign bus_sda   = m_sda & ~sda_pull_low;
  assign reg_rdata = mem[reg_addr];

  i2c_strap_slave dut (
    .clk(clk), .rst_n(rst_n), .strap_pins(strap), .scl_in(m_scl), .sda_in(bus_sda),
    .sda_pull_low(sda_pull_low), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  // R11 monitor: output must not move while the bus clock has been high for a while
  always @(posedge clk) begin
    scl_hi <= m_scl ? scl_hi + 1 : 0;
    if (rst_n && (sda_pull_low != prev_drv) && scl_hi >= 4) viol <= viol + 1;
    prev_drv <= sda_pull_low;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, output logic r);
    wclk(6); m_sda = b;
    wclk(4); m_scl = 1'b1;
    wclk(5); r = bus_sda;
    wclk(5); m_scl = 1'b0;
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; m_scl = 1'b1; wclk(10);
    m_sda = 1'b0; wclk(10);
    m_scl = 1'b0; wclk(2);
  endtask

  task automatic i2c_rstart();
    wclk(6); m_sda = 1'b1;
    wclk(4); m_scl = 1'b1;
    wclk(10); m_sda = 1'b0;
    wclk(10); m_scl = 1'b0; wclk(2);
  endtask

  task automatic i2c_stop();
    wclk(6); m_sda = 1'b0;
    wclk(4); m_scl = 1'b1;
    wclk(10); m_sda = 1'b1; wclk(10);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    logic r;
    for (int i = 7; i > 7 - n; i--) bit_cycle(v[i], r);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic r;
    send_bits(v, 8);
    bit_cycle(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, r);
      d[i] = r;
    end
    bit_cycle(!mack, r);
  endtask

  task automatic do_reset(input logic [3:0] pins);
    rst_n = 1'b0; strap = pins;
    wclk(5);
    check(!sda_pull_low && !reg_we, "R1 reset outputs", {sda_pull_low, reg_we}, 0);
    rst_n = 1'b1;
    wclk(3);
    strap = ~pins;
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    int w0;

    do_reset(4'hA);

    // strap sweep: every strap value, pins moved after capture
    for (int s = 0; s < 16; s++) begin
      do_reset(4'(s));
      i2c_start(); send_byte(8'(((8'h20 | s) << 1)), ack); i2c_stop();
      check(ack, "R2 own write address acked", ack, 1);
      i2c_start(); send_byte(8'(((8'h20 | (~s & 4'hF)) << 1)), ack); i2c_stop();
      check(!ack, "R3 post-reset pin value ignored", ack, 0);
      i2c_start(); send_byte(8'(((8'h20 | s) << 1) | 1), ack);
      check(ack, "R2 own read address acked", ack, 1);
      if (ack) recv_byte(1'b0, d);
      i2c_stop();
      check(d == init_val(0), "R7 read at reset pointer", d, init_val(0));
    end

    do_reset(4'hF);

    // full address-byte sweep with the default strap
    for (int a = 0; a < 256; a++) begin
      bit exp;
      exp = (a[7:1] == 7'h2F) || (a == 8'h30);
      i2c_start(); send_byte(8'(a), ack);
      if (ack && a[0]) recv_byte(1'b0, d);
      i2c_stop();
      if (a[7:1] == 7'h2F)            check(ack == exp, "R2 address sweep", ack, exp);
      else if (a[7:1] == 7'h18)       check(ack == exp, "R4 global address sweep", ack, exp);
      else                            check(ack == exp, "R5 foreign address sweep", ack, exp);
    end

    // R6 burst write
    w0 = wr_cnt;
    i2c_start(); send_byte(8'h5E, ack);
    send_byte(8'h10, ack); check(ack, "R6 pointer byte acked", ack, 1);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'hC1 + 8'(k), ack); check(ack, "R6 data byte acked", ack, 1);
    end
    i2c_stop();
    for (int k = 0; k < 3; k++)
      check(mem[8'h10 + k] == 8'hC1 + 8'(k), "R6 burst data", mem[8'h10 + k], 8'hC1 + k);
    check(wr_cnt - w0 == 3, "R12 one strobe per byte", wr_cnt - w0, 3);

    // R9 set pointer then repeated START into a read; R7 increments
    i2c_start(); send_byte(8'h5E, ack); send_byte(8'h40, ack);
    i2c_rstart(); send_byte(8'h5F, ack);
    check(ack, "R9 read after repeated start acked", ack, 1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k < 2, d);
      check(d == init_val(8'h40 + k), "R7 sequential read", d, init_val(8'h40 + k));
    end
    wclk(20);
    check(!sda_pull_low && bus_sda, "R8 released after NACK", sda_pull_low, 0);
    i2c_stop();
    i2c_start(); send_byte(8'h5F, ack); recv_byte(1'b0, d); i2c_stop();
    check(d == init_val(8'h43), "R7 pointer kept across transfers", d, init_val(8'h43));

    // R4 global write
    i2c_start(); send_byte(8'h30, ack); check(ack, "R4 global acked", ack, 1);
    send_byte(8'h80, ack); send_byte(8'h77, ack); i2c_stop();
    check(mem[8'h80] == 8'h77, "R4 global write data", mem[8'h80], 8'h77);

    // R5 foreign address then data bytes
    w0 = wr_cnt;
    i2c_start(); send_byte(8'h5C, ack); check(!ack, "R5 foreign not acked", ack, 0);
    send_byte(8'h00, ack); check(!ack, "R5 later byte not acked", ack, 0);
    send_byte(8'h99, ack); check(!ack, "R5 later byte not acked", ack, 0);
    i2c_stop();
    check(wr_cnt == w0, "R5 no write", wr_cnt - w0, 0);

    // R10 aborts mid-byte
    w0 = wr_cnt;
    i2c_start(); send_byte(8'h5E, ack); send_byte(8'h20, ack);
    send_bits(8'hFF, 4); i2c_stop();
    check(wr_cnt == w0, "R10 STOP discards partial byte", wr_cnt - w0, 0);
    check(mem[8'h20] == init_val(8'h20), "R10 target untouched", mem[8'h20], init_val(8'h20));
    i2c_start(); send_byte(8'h5E, ack); send_byte(8'h21, ack);
    send_bits(8'hAA, 5);
    i2c_rstart(); send_byte(8'h5E, ack); check(ack, "R10 address after abort acked", ack, 1);
    send_byte(8'h22, ack); send_byte(8'h3C, ack); i2c_stop();
    check(wr_cnt - w0 == 1, "R10 START discards partial byte", wr_cnt - w0, 1);
    check(mem[8'h22] == 8'h3C, "R10 write after abort", mem[8'h22], 8'h3C);
    check(mem[8'h21] == init_val(8'h21), "R10 aborted target untouched", mem[8'h21], init_val(8'h21));

    check(viol == 0, "R11 output stable while clock high", viol, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule